// File: doc/BRIEF.md
# Soft-Ramp Channel Attenuator

This block scales eight channels of 24-bit signed audio samples by a per-channel attenuation between 0 dB and -127 dB. Software supplies a target in half-decibel steps. Internally each channel keeps an applied level counted in eighth-decibel units. That level walks toward the target one unit at a time, at a pace chosen by a rate field shared by every channel, so that gain changes do not produce audible steps. A per-channel mute drives the target to the bottom of the range. Clearing the mute lets the level climb back to the programmed setting along the same kind of ramp.

Each channel has a small state machine with three states. HOLD means the applied level equals the target. DOWN means the target is deeper, so the level grows by one unit on each step opportunity. UP means the target is shallower, so the level shrinks by one unit on each step opportunity. The transitions are HOLD->DOWN and UP->DOWN when the target becomes deeper than the level, HOLD->UP and DOWN->UP when the target becomes shallower than the level, and DOWN->HOLD and UP->HOLD when the level reaches the target.

A separate detector watches the sample stream. It raises an auto-mute flag once every channel has carried zero for a long unbroken run of samples.

Top module: `soft_vol_top`

## Requirements
- R1: Each channel's 8-bit setting `a` (0..254) requests an attenuation of `a`/2 dB. The matching target is `4*a` eighth-dB units, and the applied level never leaves the range 0..1016.
- R2: With rate code 1, every accepted sample moves the applied level one unit toward its target, in the correct direction, and never past the target.
- R3: With rate code 2, the level steps only on samples where a shared count of accepted samples since reset, taken modulo 4, is 0. With rate code 3, it steps only where that count modulo 16 is 0.
- R4: With rate code 0, the applied level becomes equal to the target on the next accepted sample.
- R5: While a channel's mute bit is 1, its target is 1016 units. The level ramps there at the selected rate and then stays there, and the channel outputs 0.
- R6: After a channel's mute bit returns to 0, its level ramps back to `4*a` at the selected rate.
- R7: The gain for level `u` is `(65536 - floor((u mod 48)*32768/48)) >> floor(u/48)`. Each output is `floor((x*gain + 32768) / 65536)`, clamped to the signed 24-bit range.
- R8: Outputs register one cycle after an accepted sample, using the level held before that sample's step. `smp_out_valid` follows `smp_valid` by one cycle, and `smp_out` holds its value when no sample is accepted.
- R9: `auto_mute` rises on the 8192nd consecutive accepted sample in which all eight channels are zero, and not earlier.
- R10: `auto_mute` falls on the first accepted sample in which any channel is nonzero.
- R11: After reset, `smp_out`, `smp_out_valid` and `auto_mute` are 0, and every applied level is 0.
- R12: Each channel's level, mute and output depend only on that channel's own setting, mute bit and input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample frame is present this cycle |
| smp_in | input | 192 | Eight signed 24-bit samples, channel 0 in the low bits |
| att_set | input | 64 | Eight 8-bit attenuation settings in half-dB units |
| mute_set | input | 8 | Per-channel mute request |
| ramp_rate | input | 2 | Shared ramp pace: 0 immediate, 1 every sample, 2 every 4th, 3 every 16th |
| smp_out | output | 192 | Eight scaled samples |
| smp_out_valid | output | 1 | `smp_out` updated this cycle |
| auto_mute | output | 1 | Long all-zero run detected |

## Verification
The bench drives the ports with a cycle-accurate arithmetic model and compares every output word on every sample. It sweeps every setting under immediate mode, using different data on each channel. A design with a wrong gain curve, wrong rounding or swapped channel lanes would mismatch on some value in that sweep.

The ramp phases use all three paced rates, mute and unmute with full-scale positive and negative data, and idle cycles between samples. A design that steps by more than one unit, steps on the wrong samples or overshoots the target would drift from the expected level. The same is true of a design that also steps on idle cycles, or that applies a new level one sample early.

The zero run covers samples 8191 and 8192 and then a single nonzero sample. This catches an off-by-one in the auto-mute count and a flag that is slow to clear.

// File: rtl/svol_pkg.sv
package svol_pkg;
    localparam int ATT_W = 8;
    localparam int U_W   = 10;
    localparam int MAX_U = 1016;
    localparam int G_W   = 17;

    typedef enum logic [1:0] {ST_HOLD, ST_DOWN, ST_UP} ramp_st_t;
    typedef enum logic [1:0] {RATE_NOW, RATE_1, RATE_4, RATE_16} rate_t;

    function automatic logic [G_W-1:0] gain_of(input logic [U_W-1:0] u);
        logic [4:0]  sh;
        logic [5:0]  fr;
        logic [21:0] num;
        logic [G_W-1:0] m;
        sh  = 5'(u / 10'd48);
        fr  = 6'(u % 10'd48);
        num = {1'b0, fr, 15'b0};
        m   = 17'd65536 - 17'(num / 22'd48);
        return m >> sh;
    endfunction
endpackage

// File: rtl/vol_ramp_ch.sv
module vol_ramp_ch
    import svol_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             tick,
    input  logic [1:0]       rate,
    input  logic [ATT_W-1:0] att,
    input  logic             mute,
    output logic [U_W-1:0]   level
);
    ramp_st_t       st, nxt;
    logic [U_W-1:0] goal, level_d;

    assign goal = mute ? U_W'(MAX_U) : U_W'({att, 2'b00});

    always_comb begin
        if (goal > level)      nxt = ST_DOWN;
        else if (goal < level) nxt = ST_UP;
        else                   nxt = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HOLD;
        else        st <= nxt;
    end

    always_comb begin
        level_d = level;
        if (smp_valid) begin
            if (rate_t'(rate) == RATE_NOW) begin
                level_d = goal;
            end else if (tick) begin
                unique case (nxt)
                    ST_DOWN: level_d = level + U_W'(1);
                    ST_UP:   level_d = level - U_W'(1);
                    ST_HOLD: level_d = level;
                    default: level_d = level;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= level_d;
    end

    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= U_W'(MAX_U));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && tick && rate != 2'd0 && goal > level) |=> level == $past(level) + U_W'(1));

    p_hold_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !smp_valid) |=> $stable(level));

    p_mute_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && level == U_W'(MAX_U)) |=> level == U_W'(MAX_U));
endmodule

// File: rtl/gain_scale.sv
module gain_scale
    import svol_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic [DW-1:0]  din,
    input  logic [U_W-1:0] level,
    output logic [DW-1:0]  dout
);
    localparam int PW = DW + G_W + 1;
    localparam logic signed [PW-1:0] HI = PW'((64'sd1 <<< (DW-1)) - 1);
    localparam logic signed [PW-1:0] LO = -PW'(64'sd1 <<< (DW-1));

    logic [G_W-1:0]         g;
    logic signed [PW-1:0]   prod, rnd, sh;

    always_comb begin
        g    = gain_of(level);
        prod = PW'($signed(din)) * $signed({1'b0, g});
        rnd  = prod + PW'(32768);
        sh   = rnd >>> 16;
        if (sh > HI)      dout = HI[DW-1:0];
        else if (sh < LO) dout = LO[DW-1:0];
        else              dout = sh[DW-1:0];
    end
endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
    parameter int NCH = 8,
    parameter int DW  = 24,
    parameter int LEN = 8192
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [NCH*DW-1:0] smp_in,
    output logic            flag
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;
    logic          all_zero;

    assign all_zero = (smp_in == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (smp_valid) begin
            if (all_zero) begin
                if (cnt != CW'(LEN)) cnt <= cnt + CW'(1);
                flag <= (cnt >= CW'(LEN - 1));
            end else begin
                cnt  <= '0;
                flag <= 1'b0;
            end
        end
    end

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !all_zero) |=> !flag);

    p_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(smp_valid && all_zero));
endmodule

// File: rtl/soft_vol_top.sv
module soft_vol_top
    import svol_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int DW       = 24,
    parameter int ZERO_LEN = 8192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [NCH*DW-1:0]    smp_in,
    input  logic [NCH*ATT_W-1:0] att_set,
    input  logic [NCH-1:0]       mute_set,
    input  logic [1:0]           ramp_rate,
    output logic [NCH*DW-1:0]    smp_out,
    output logic                 smp_out_valid,
    output logic                 auto_mute
);
    logic [3:0]  smp_cnt;
    logic        tick;
    logic [NCH*DW-1:0] scaled;

    always_ff @(posedge clk) begin
        if (!rst_n)         smp_cnt <= '0;
        else if (smp_valid) smp_cnt <= smp_cnt + 4'd1;
    end

    always_comb begin
        unique case (rate_t'(ramp_rate))
            RATE_NOW: tick = 1'b1;
            RATE_1:   tick = 1'b1;
            RATE_4:   tick = (smp_cnt[1:0] == 2'd0);
            RATE_16:  tick = (smp_cnt == 4'd0);
            default:  tick = 1'b0;
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [U_W-1:0] lvl;

        vol_ramp_ch u_ramp (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .tick      (tick),
            .rate      (ramp_rate),
            .att       (att_set[c*ATT_W +: ATT_W]),
            .mute      (mute_set[c]),
            .level     (lvl)
        );

        gain_scale #(.DW(DW)) u_scale (
            .din   (smp_in[c*DW +: DW]),
            .level (lvl),
            .dout  (scaled[c*DW +: DW])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)         smp_out[c*DW +: DW] <= '0;
            else if (smp_valid) smp_out[c*DW +: DW] <= scaled[c*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_out_valid <= 1'b0;
        else        smp_out_valid <= smp_valid;
    end

    zero_detect #(.NCH(NCH), .DW(DW), .LEN(ZERO_LEN)) u_zero (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_in    (smp_in),
        .flag      (auto_mute)
    );

    p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_out_valid == $past(smp_valid));

    p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(smp_out));
endmodule

// File: tb/tb_soft_vol_top.sv
module tb_soft_vol_top;
    localparam int NCH = 8;
    localparam int DW  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [NCH*DW-1:0] smp_in = '0;
    logic [NCH*8-1:0]  att_set = '0;
    logic [NCH-1:0]    mute_set = '0;
    logic [1:0]        ramp_rate = '0;
    logic [NCH*DW-1:0] smp_out;
    logic              smp_out_valid;
    logic              auto_mute;

    always #10 clk = ~clk;

    soft_vol_top dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
        .att_set(att_set), .mute_set(mute_set), .ramp_rate(ramp_rate),
        .smp_out(smp_out), .smp_out_valid(smp_out_valid), .auto_mute(auto_mute)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int att_m [NCH];
    bit mute_m [NCH];
    int data_m [NCH];
    int rate_m = 0;
    bit valid_m = 1;

    int lvl [NCH];
    int cnt_m = 0;
    int zrun = 0;
    int exp_out [NCH];
    bit exp_valid = 0;
    bit exp_am = 0;
    bit pend = 0;
    string pend_tag;

    function automatic longint gain(input int u);
        longint m;
        m = 65536 - ((u % 48) * 32768) / 48;
        return m >>> (u / 48);
    endfunction

    function automatic int scale(input int x, input int u);
        longint p;
        p = (longint'(x) * gain(u) + 32768) >>> 16;
        if (p > 8388607) p = 8388607;
        if (p < -8388608) p = -8388608;
        return int'(p);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_pending();
        if (!pend) return;
        chk("R8 valid", smp_out_valid, exp_valid);
        chk("R9 R10 auto_mute", auto_mute, exp_am);
        for (int c = 0; c < NCH; c++)
            chk(pend_tag, longint'($signed(smp_out[c*DW +: DW])), exp_out[c]);
    endtask

    task automatic do_sample(input string tag);
        bit tk;
        bit allz;
        int goal;
        @(negedge clk);
        compare_pending();
        smp_valid = valid_m;
        ramp_rate = 2'(rate_m);
        allz = 1;
        for (int c = 0; c < NCH; c++) begin
            smp_in[c*DW +: DW] = DW'(data_m[c]);
            att_set[c*8 +: 8]  = 8'(att_m[c]);
            mute_set[c]        = mute_m[c];
            if (data_m[c] != 0) allz = 0;
        end
        exp_valid = valid_m;
        if (valid_m) begin
            case (rate_m)
                2: tk = (cnt_m % 4) == 0;
                3: tk = (cnt_m % 16) == 0;
                default: tk = 1;
            endcase
            cnt_m = (cnt_m + 1) % 16;
            for (int c = 0; c < NCH; c++) begin
                exp_out[c] = scale(data_m[c], lvl[c]);
                goal = mute_m[c] ? 1016 : 4 * att_m[c];
                if (rate_m == 0) lvl[c] = goal;
                else if (tk && goal > lvl[c]) lvl[c]++;
                else if (tk && goal < lvl[c]) lvl[c]--;
            end
            if (allz) begin
                exp_am = (zrun >= 8191);
                if (zrun < 8192) zrun++;
            end else begin
                exp_am = 0;
                zrun = 0;
            end
        end
        pend = 1;
        pend_tag = tag;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            att_m[c] = 0; mute_m[c] = 0; data_m[c] = 0; lvl[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 out_valid", smp_out_valid, 0);
        chk("R11 auto_mute", auto_mute, 0);
        chk("R11 out", longint'(smp_out == '0), 1);

        rate_m = 0;
        for (int a = 0; a < 255; a++) begin
            for (int c = 0; c < NCH; c++) begin
                att_m[c] = (a + c * 31) % 255;
                data_m[c] = ((a * 7919 + c * 104729 + 12345) % 16777216) - 8388608;
            end
            do_sample("R1 R4 R7 R12 sweep");
        end

        rate_m = 1;
        for (int c = 0; c < NCH; c++) att_m[c] = c * 3 + 1;
        for (int i = 0; i < 60; i++) begin
            for (int c = 0; c < NCH; c++) data_m[c] = (i % 2) ? -8388608 : 8388607;
            valid_m = (i % 7) != 3;
            do_sample("R2 R8 ramp");
        end
        valid_m = 1;

        rate_m = 2;
        for (int c = 0; c < NCH; c++) att_m[c] = 5 + c;
        for (int i = 0; i < 120; i++) do_sample("R3 rate4");
        rate_m = 3;
        for (int c = 0; c < NCH; c++) att_m[c] = 0;
        for (int i = 0; i < 500; i++) do_sample("R3 rate16");

        rate_m = 1;
        for (int c = 0; c < NCH; c++) begin
            att_m[c] = 10 * c;
            mute_m[c] = (c % 2) == 0;
            data_m[c] = (c % 3 == 0) ? -8388608 : 8388607;
        end
        for (int i = 0; i < 1100; i++) do_sample("R5 R12 mute");
        for (int c = 0; c < NCH; c++) mute_m[c] = 0;
        for (int i = 0; i < 1100; i++) do_sample("R6 unmute");

        for (int c = 0; c < NCH; c++) data_m[c] = 0;
        for (int i = 0; i < 8200; i++) do_sample("R9 zero run");
        data_m[5] = 1;
        do_sample("R10 nonzero");
        data_m[5] = 0;
        do_sample("R10 after");
        do_sample("R10 after");
        @(negedge clk);
        compare_pending();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule